// File: doc/BRIEF.md
# Posted Write Buffer for Memory Writes

This block sits between the second-level cache and main memory. It takes in writes headed for memory and holds them, so the requester can move on as soon as a write is accepted. The requester waits only when every slot is taken. Held writes go out to memory one at a time, in the order they arrived. The front entry stays in place until memory acknowledges it.

Each write is one of two kinds. A byte write carries its full 24-bit byte address and one data byte. A line write carries a whole 16-byte line. That line is identified by its 20-bit block tag, because the line covers every address from tag×16 to tag×16+15. To save storage, both kinds share one payload field in each slot. A kind bit says how to read that field. On the memory side, a line write's address is rebuilt as the tag followed by four zero bits.

Top module: `post_wbuf`

## Requirements
- R1: After reset, `mem_valid` is 0, `wr_ready` is 1 and `stall` is 0.
- R2: A byte write (`wr_is_line`=0) appears on the memory side as follows. `mem_is_line` is 0 and `mem_addr` equals the full 24-bit `wr_addr`. `mem_data[7:0]` equals `wr_byte` and `mem_data[127:8]` is zero.
- R3: A line write (`wr_is_line`=1) appears on the memory side as follows. `mem_is_line` is 1 and `mem_addr` is `{wr_addr[23:4], 4'h0}`, so `wr_addr[3:0]` has no effect. `mem_data` equals `wr_line`.
- R4: Writes reach the memory side in the order they were accepted, and each one is presented once.
- R5: While `mem_valid` is 1 and `mem_ack` is 0, the presented entry stays unchanged. The entry is removed at the clock edge where `mem_valid` and `mem_ack` are both 1.
- R6: A write is accepted at a clock edge where `wr_valid` and `wr_ready` are both 1. If the buffer was empty, the write is presented on the memory side right after that edge.
- R7: With 4 entries held, `stall` is 1. `wr_ready` is 0 unless `mem_ack` is 1. A write offered in that state without `mem_ack` is not stored.
- R8: When the buffer is full and `mem_ack` is 1, `wr_ready` is 1. A write accepted then and the removal of the front entry take place at the same edge, and `stall` stays 1.
- R9: A `mem_ack` while the buffer is empty has no effect. The next write is presented normally, and the buffer then fills only after 4 writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | A write is offered |
| wr_ready | output | 1 | The buffer can take the offered write |
| wr_is_line | input | 1 | 1 = whole-line write, 0 = byte write |
| wr_addr | input | 24 | Byte address (a line write uses bits 23:4 only) |
| wr_byte | input | 8 | Data of a byte write |
| wr_line | input | 128 | Data of a line write |
| stall | output | 1 | Buffer full, so the requester must wait |
| mem_valid | output | 1 | An entry is presented to memory |
| mem_is_line | output | 1 | Kind of the presented entry |
| mem_addr | output | 24 | Address of the presented entry (line: tag with zero offset) |
| mem_data | output | 128 | Data of the presented entry (byte in bits 7:0) |
| mem_ack | input | 1 | Memory takes the presented entry |

## Verification
An accepted write is presented to memory in the first cycle after the edge that took it in. An acknowledged entry is gone, or replaced by the next one, in the first cycle after the acknowledging edge. `wr_ready` responds to `mem_ack` within the same cycle, with no clock edge between them. The bench changes inputs on the falling edge. It reads registered results at the next falling edge, after the rising edge that updates them. It reads `wr_ready` one time step after changing `mem_ack`, before the next rising edge.

// File: rtl/pwb_pkg.sv
// Shared widths and the stored entry type for the posted write buffer.
// Assumes a byte-addressed memory and lines of 2**OFF_W bytes.
package pwb_pkg;
    localparam int ADDR_W = 24;
    localparam int OFF_W  = 4;
    localparam int BYTE_W = 8;
    localparam int TAG_W  = ADDR_W - OFF_W;
    localparam int LINE_W = BYTE_W << OFF_W;
    localparam int LINE_PAY_W = TAG_W + LINE_W;
    localparam int BYTE_PAY_W = ADDR_W + BYTE_W;
    localparam int PAY_W = (LINE_PAY_W > BYTE_PAY_W) ? LINE_PAY_W : BYTE_PAY_W;

    typedef enum logic {
        KIND_BYTE = 1'b0,
        KIND_LINE = 1'b1
    } kind_e;

    typedef struct packed {
        kind_e            kind;
        logic [PAY_W-1:0] pay;
    } entry_t;
endpackage

// File: rtl/pwb_pack.sv
// Folds an incoming write into the shared payload layout.
// Byte kind: address above the data byte. Line kind: block tag above line data.
// Assumes the address offset bits of a line write are meaningless.
module pwb_pack
    import pwb_pkg::*;
(
    input  logic              is_line,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] byte_d,
    input  logic [LINE_W-1:0] line_d,
    output entry_t            ent
);
    // Select the layout by kind and zero the unused payload bits.
    always_comb begin
        ent.pay = '0;
        if (is_line) begin
            ent.kind = KIND_LINE;
            ent.pay[LINE_PAY_W-1:LINE_W] = addr[ADDR_W-1:OFF_W];
            ent.pay[LINE_W-1:0]          = line_d;
        end else begin
            ent.kind = KIND_BYTE;
            ent.pay[BYTE_PAY_W-1:BYTE_W] = addr;
            ent.pay[BYTE_W-1:0]          = byte_d;
        end
    end
endmodule

// File: rtl/pwb_unpack.sv
// Expands a stored entry into a memory-side address and data word.
// A line address is rebuilt from its tag with a zero offset; a byte sits in the low data bits.
module pwb_unpack
    import pwb_pkg::*;
(
    input  entry_t            ent,
    output logic              is_line,
    output logic [ADDR_W-1:0] addr,
    output logic [LINE_W-1:0] data
);
    // Decode the payload according to the kind bit.
    always_comb begin
        is_line = (ent.kind == KIND_LINE);
        if (is_line) begin
            addr = {ent.pay[LINE_PAY_W-1:LINE_W], {OFF_W{1'b0}}};
            data = ent.pay[LINE_W-1:0];
        end else begin
            addr = ent.pay[BYTE_PAY_W-1:BYTE_W];
            data = {{(LINE_W-BYTE_W){1'b0}}, ent.pay[BYTE_W-1:0]};
        end
    end
endmodule

// File: rtl/pwb_store.sv
// Circular entry storage with separate write and read pointers.
// Assumes the caller never pushes when full (unless popping) nor pops when empty.
// The head entry is read without a register stage.
module pwb_store
    import pwb_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   push,
    input  logic   pop,
    input  entry_t din,
    output entry_t head
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    entry_t           slots_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q;
    logic [PTR_W-1:0] rd_ptr_q;
    logic [PTR_W-1:0] wr_nxt;
    logic [PTR_W-1:0] rd_nxt;

    // Pointer advance: natural wrap for power-of-two depth, explicit wrap otherwise.
    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
            always_comb begin
                wr_nxt = wr_ptr_q + 1'b1;
                rd_nxt = rd_ptr_q + 1'b1;
            end
        end else begin : g_wrap
            always_comb begin
                wr_nxt = (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
                rd_nxt = (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
            end
        end
    endgenerate

    // Pointer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
        end else begin
            if (push) wr_ptr_q <= wr_nxt;
            if (pop)  rd_ptr_q <= rd_nxt;
        end
    end

    // Entry write at the tail slot.
    always_ff @(posedge clk) begin
        if (push) slots_q[wr_ptr_q] <= din;
    end

    // Head entry read.
    assign head = slots_q[rd_ptr_q];
endmodule

// File: rtl/pwb_count.sv
// Occupancy counter that produces the full and empty flags.
// Assumes push is never given when full without pop, nor pop when empty.
module pwb_count #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic pop,
    output logic full,
    output logic empty
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] cnt_q;

    // Occupancy update; push and pop together leave it unchanged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Flags from the count.
    assign full  = (cnt_q == CNT_W'(DEPTH));
    assign empty = (cnt_q == '0);
endmodule

// File: rtl/post_wbuf.sv
// Posted write buffer between a cache and main memory.
// Takes byte or line writes over a valid/ready port and drains them in order,
// one at a time, each removed on a memory acknowledge.
// Assumes mem_ack is only meaningful while mem_valid is high.
module post_wbuf
    import pwb_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic              wr_is_line,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic [LINE_W-1:0] wr_line,
    output logic              stall,
    output logic              mem_valid,
    output logic              mem_is_line,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0] mem_data,
    input  logic              mem_ack
);
    entry_t in_ent;
    entry_t head_ent;
    logic   full;
    logic   empty;
    logic   push;
    logic   pop;

    // Handshake decisions; a full buffer still takes a write when the head leaves.
    always_comb begin
        pop      = !empty && mem_ack;
        wr_ready = !full || mem_ack;
        push     = wr_valid && wr_ready;
    end

    assign stall     = full;
    assign mem_valid = !empty;

    pwb_pack u_pack (
        .is_line (wr_is_line),
        .addr    (wr_addr),
        .byte_d  (wr_byte),
        .line_d  (wr_line),
        .ent     (in_ent)
    );

    pwb_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .din   (in_ent),
        .head  (head_ent)
    );

    pwb_count #(.DEPTH(DEPTH)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .full  (full),
        .empty (empty)
    );

    pwb_unpack u_unpack (
        .ent     (head_ent),
        .is_line (mem_is_line),
        .addr    (mem_addr),
        .data    (mem_data)
    );
endmodule

// File: rtl/pwb_chk.sv
// Port-level checker for post_wbuf, attached by bind.
// Keeps its own occupancy model built only from port handshakes.
module pwb_chk
    import pwb_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic              stall,
    input logic              mem_valid,
    input logic              mem_is_line,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [LINE_W-1:0] mem_data,
    input logic              mem_ack
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] occ_q;

    // Occupancy model from accepted and acknowledged handshakes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= '0;
        end else begin
            case ({wr_valid && wr_ready, mem_valid && mem_ack})
                2'b10:   occ_q <= occ_q + 1'b1;
                2'b01:   occ_q <= occ_q - 1'b1;
                default: occ_q <= occ_q;
            endcase
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!mem_valid && wr_ready && !stall));

    // R3
    line_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_is_line) |-> (mem_addr[OFF_W-1:0] == '0));

    // R5
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ack) |=> (mem_valid && $stable(mem_addr)
                                     && $stable(mem_data) && $stable(mem_is_line)));

    // R7
    stall_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall == (occ_q == CNT_W'(DEPTH)));

    // R7
    full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !mem_ack) |-> !wr_ready);

    // R8
    full_ack_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && mem_ack) |-> wr_ready);

    // R9
    empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q == '0) |-> (!mem_valid && wr_ready));
endmodule

bind post_wbuf pwb_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .wr_ready    (wr_ready),
    .stall       (stall),
    .mem_valid   (mem_valid),
    .mem_is_line (mem_is_line),
    .mem_addr    (mem_addr),
    .mem_data    (mem_data),
    .mem_ack     (mem_ack)
);

// File: tb/sim_post_wbuf.sv
// Bench for post_wbuf: a vector table walked one write at a time, then directed
// tests of reset, filling, full-with-acknowledge and acknowledge while empty.
module sim_post_wbuf;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_valid = 1'b0;
    logic         wr_ready;
    logic         wr_is_line = 1'b0;
    logic [23:0]  wr_addr = '0;
    logic [7:0]   wr_byte = '0;
    logic [127:0] wr_line = '0;
    logic         stall;
    logic         mem_valid;
    logic         mem_is_line;
    logic [23:0]  mem_addr;
    logic [127:0] mem_data;
    logic         mem_ack = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    post_wbuf u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_is_line(wr_is_line), .wr_addr(wr_addr), .wr_byte(wr_byte),
        .wr_line(wr_line), .stall(stall), .mem_valid(mem_valid),
        .mem_is_line(mem_is_line), .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_ack(mem_ack)
    );

    typedef struct packed {
        logic         is_line;
        logic [23:0]  addr;
        logic [7:0]   b;
        logic [127:0] line;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 24'hAB7129, 8'h5A, 128'h0},
        '{1'b1, 24'hAB712F, 8'h00, 128'h00112233_44556677_8899AABB_CCDDEEFF},
        '{1'b0, 24'h000000, 8'hFF, 128'h0},
        '{1'b1, 24'hCD1120, 8'h77, 128'hFFFFFFFF_00000000_FFFFFFFF_00000000},
        '{1'b0, 24'hFFFFFF, 8'h01, 128'hDEAD},
        '{1'b1, 24'hFFFFF7, 8'h00, 128'h1}
    };

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_addr(input vec_t v);
        return v.is_line ? {v.addr[23:4], 4'h0} : v.addr;
    endfunction

    function automatic logic [127:0] exp_data(input vec_t v);
        return v.is_line ? v.line : {120'h0, v.b};
    endfunction

    // Offer a write at a falling edge; it is taken at the next rising edge.
    task automatic push(input vec_t v);
        wr_valid   = 1'b1;
        wr_is_line = v.is_line;
        wr_addr    = v.addr;
        wr_byte    = v.b;
        wr_line    = v.line;
        @(posedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    // Check the presented entry, then acknowledge it for one edge.
    task automatic pop_expect(input string req, input vec_t v);
        check(req, {127'h0, mem_valid}, 128'h1);
        check(req, {127'h0, mem_is_line}, {127'h0, v.is_line});
        check(req, {104'h0, mem_addr}, {104'h0, exp_addr(v)});
        check(req, mem_data, exp_data(v));
        mem_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        mem_ack = 1'b0;
    endtask

    function automatic vec_t mk_byte(input logic [23:0] a, input logic [7:0] d);
        vec_t v;
        v.is_line = 1'b0;
        v.addr    = a;
        v.b       = d;
        v.line    = '0;
        return v;
    endfunction

    // Watchdog: an expired run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected<20000", cycles);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        vec_t e1, e2, e3, e4, ex, ee, ez;
        e1 = mk_byte(24'h100001, 8'hA1);
        e2 = mk_byte(24'h200002, 8'hB2);
        e3 = mk_byte(24'h300003, 8'hC3);
        e4 = mk_byte(24'h400004, 8'hD4);
        ex = mk_byte(24'h0BAD00, 8'hEE);
        ez = mk_byte(24'h777777, 8'h77);
        ee.is_line = 1'b1;
        ee.addr    = 24'h55555A;
        ee.b       = 8'h00;
        ee.line    = 128'hCAFE_F00D;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", {127'h0, mem_valid}, 128'h0);
        check("R1", {127'h0, wr_ready}, 128'h1);
        check("R1", {127'h0, stall}, 128'h0);

        // R2 R3 R6: each table write appears right after it is taken, then drains.
        for (int i = 0; i < NV; i++) begin
            push(VEC[i]);
            pop_expect(VEC[i].is_line ? "R3" : "R2", VEC[i]);
            check("R6", {127'h0, mem_valid}, 128'h0);
        end

        // R4: two table writes back to back drain in order.
        push(VEC[1]);
        push(VEC[0]);
        pop_expect("R4", VEC[1]);
        pop_expect("R4", VEC[0]);

        // R7: fill to four entries.
        push(e1);
        push(e2);
        push(e3);
        check("R7", {127'h0, stall}, 128'h0);
        push(e4);
        check("R7", {127'h0, stall}, 128'h1);
        check("R7", {127'h0, wr_ready}, 128'h0);
        // R7: an offered write without acknowledge is refused.
        wr_valid = 1'b1; wr_is_line = ex.is_line; wr_addr = ex.addr; wr_byte = ex.b;
        #1 check("R7", {127'h0, wr_ready}, 128'h0);
        @(posedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
        // R5: the head stays while no acknowledge is given.
        check("R5", {104'h0, mem_addr}, {104'h0, e1.addr});
        check("R5", mem_data, {120'h0, e1.b});

        // R8: full with acknowledge takes a new write and drops the head together.
        mem_ack = 1'b1;
        wr_valid = 1'b1; wr_is_line = ee.is_line; wr_addr = ee.addr; wr_line = ee.line;
        #1 check("R8", {127'h0, wr_ready}, 128'h1);
        @(posedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
        mem_ack  = 1'b0;
        check("R8", {127'h0, stall}, 128'h1);
        check("R8", {104'h0, mem_addr}, {104'h0, e2.addr});

        // R4 R7: the remaining order, with no trace of the refused write.
        pop_expect("R4", e2);
        pop_expect("R4", e3);
        pop_expect("R4", e4);
        pop_expect("R8", ee);
        check("R7", {127'h0, mem_valid}, 128'h0);

        // R9: acknowledge while empty has no effect.
        mem_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        mem_ack = 1'b0;
        check("R9", {127'h0, mem_valid}, 128'h0);
        check("R9", {127'h0, wr_ready}, 128'h1);
        push(ez);
        push(e1);
        push(e2);
        check("R9", {127'h0, stall}, 128'h0);
        push(e3);
        check("R9", {127'h0, stall}, 128'h1);
        pop_expect("R9", ez);
        pop_expect("R9", e1);
        pop_expect("R9", e2);
        pop_expect("R9", e3);
        check("R9", {127'h0, mem_valid}, 128'h0);

        // R1: reset in the middle of a fill returns to idle.
        push(e1);
        push(e2);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {127'h0, mem_valid}, 128'h0);
        check("R1", {127'h0, stall}, 128'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule